// File: doc/BRIEF.md
# Block-Transfer Channel Sequencer

This block turns one high-level transfer request into a run of single dataway read operations. A request carries a six-bit mode word made of three independent fields: the address field selects how the next address is formed, the pacing field selects what must be true before each operation is issued, and the end field selects what closes the block. The request also carries a start address, a terminal address, a word limit and a function code.

Each operation raises a one-cycle strobe with a station number, a subaddress and the function code. In that same cycle the sequencer samples the module's Q response and read data. A word that counts as valid is placed in a one-entry output slot. The host drains the slot with a valid/ready handshake, and no new operation is issued while an undrained word would be overwritten. At the end of the block a one-cycle done pulse is raised. The word total, the last address used and a cause code then remain readable until the next request is accepted.

Top module: `btx_seq`

## Requirements
- R1: Mode word layout: bit 0 is the address field (0 fixed address, 1 scan); bits 2:1 are the pacing field (0 controller, 1 Q, 2 LAM line, 3 pseudo-LAM line); bits 5:3 are the end field (0 word count, 1 terminal address, 2 Q=0 with no word, 3 Q=0 with a final word, 4 LAM line, 5 pseudo-LAM line). A request is taken when req_valid and req_ready are both high, and busy rises in the next cycle.
- R2: In fixed-address mode, every strobe of the block carries the start address and the requested function code.
- R3: An address is {station, subaddress}, compared as one unsigned number. In scan mode, Q=1 advances the subaddress by one. Q=0, or Q=1 at subaddress 15, moves to subaddress 0 of the next station. Q=0 in scan mode moves no word unless the end field is 3. The block ends with cause 2 once the next address would exceed the terminal address. With end field 1 in fixed mode, the block ends with cause 2 after a word at an address equal to the terminal address.
- R4: When the pacing condition holds and the host is ready, strobes are issued every second cycle.
- R5: With Q pacing, an operation that returns Q=0 moves no word and is repeated at the same address. Q=0 never ends the block in this pacing mode.
- R6: With LAM or pseudo-LAM pacing, a strobe is issued only in a cycle that follows a cycle in which the selected line was high.
- R7: A word counts as valid when Q=1, or when Q=0 with end field 3. When the valid-word total reaches the word limit, the block ends with cause 1, whatever end field is selected. A word limit of 0 ends the block with cause 1 and issues no strobe.
- R8: End field 2: an operation with Q=0 ends the block with cause 3 and delivers no word. End field 3: an operation with Q=0 ends the block with cause 3 and delivers its data as the final word.
- R9: End fields 4 and 5 are tested before each operation is issued. When the selected line is high, the block ends with cause 4 (LAM) or cause 5 (pseudo-LAM) and issues no further strobe.
- R10: While the output slot holds a word the host has not taken, no strobe is issued, and host_data stays stable.
- R11: After reset, req_ready is 1 and busy, done, cmd_stb and host_valid are 0. done is a one-cycle pulse at the end of a block, and busy is 0 in the following cycle. st_words, st_last (the address of the last strobe, or the start address if no strobe was issued) and st_cause then hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_mode | input | 6 | Address, pacing and end fields |
| req_start | input | NW+AW | First address {station, subaddress} |
| req_term | input | NW+AW | Terminal address |
| req_wcnt | input | CW | Word limit |
| req_func | input | FW | Function code for every operation |
| cmd_stb | output | 1 | One-cycle operation strobe |
| cmd_n | output | NW | Station number |
| cmd_a | output | AW | Subaddress |
| cmd_f | output | FW | Function code |
| dw_q | input | 1 | Q response, sampled with the strobe |
| dw_lam | input | 1 | LAM line |
| dw_plam | input | 1 | Pseudo-LAM line |
| dw_rdata | input | DW | Read data, sampled with the strobe |
| host_valid | output | 1 | Output slot holds a word |
| host_ready | input | 1 | Host takes the word |
| host_data | output | DW | Word in the output slot |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| st_words | output | CW | Valid words in the block |
| st_last | output | NW+AW | Last address strobed |
| st_cause | output | 3 | End cause: 1 count, 2 terminal, 3 Q, 4 LAM, 5 pseudo-LAM |

## Verification
A wrong address register in scan mode shows at the next strobe as a wrong cmd_n or cmd_a. It also shows when the block ends, as a different strobe total and a different st_last. A wrong word counter or end decision moves the done pulse by at least one operation, which is two cycles, and it changes st_words and st_cause. A slot or pacing fault is visible within one cycle as a strobe that arrives while a word is still held or while the pacing line is low. The same fault also changes the spacing measured between the first and the last strobe.

// File: rtl/btx_pkg.sv
package btx_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ISSUE, ST_DONE} seq_st_t;

   localparam logic [1:0] PACE_CTRL = 2'd0;
   localparam logic [1:0] PACE_Q    = 2'd1;
   localparam logic [1:0] PACE_LAM  = 2'd2;
   localparam logic [1:0] PACE_PLAM = 2'd3;

   localparam logic [2:0] END_COUNT = 3'd0;
   localparam logic [2:0] END_TERM  = 3'd1;
   localparam logic [2:0] END_QNEXT = 3'd2;
   localparam logic [2:0] END_QLAST = 3'd3;
   localparam logic [2:0] END_LAM   = 3'd4;
   localparam logic [2:0] END_PLAM  = 3'd5;

   localparam logic [2:0] CAUSE_NONE  = 3'd0;
   localparam logic [2:0] CAUSE_COUNT = 3'd1;
   localparam logic [2:0] CAUSE_TERM  = 3'd2;
   localparam logic [2:0] CAUSE_Q     = 3'd3;
   localparam logic [2:0] CAUSE_LAM   = 3'd4;
   localparam logic [2:0] CAUSE_PLAM  = 3'd5;
endpackage

// File: rtl/btx_addr_step.sv
module btx_addr_step #(
   parameter int NW = 5,
   parameter int AW = 4
) (
   input  logic [NW-1:0] cur_n,
   input  logic [AW-1:0] cur_a,
   input  logic          q,
   output logic [NW+AW:0] nxt
);
   localparam int NX = NW + 1;
   localparam logic [AW-1:0] SUB_TOP = '1;

   // Q=1 below the top subaddress steps within the station; anything
   // else opens the next station. The extra top bit keeps a station
   // overflow larger than any terminal address.
   always_comb begin
      if (q && (cur_a != SUB_TOP))
         nxt = {1'b0, cur_n, cur_a + AW'(1)};
      else
         nxt = {({1'b0, cur_n} + NX'(1)), {AW{1'b0}}};
   end
endmodule

// File: rtl/btx_gate.sv
module btx_gate
   import btx_pkg::*;
(
   input  logic [1:0] pace_sel,
   input  logic [2:0] end_sel,
   input  logic       lam,
   input  logic       plam,
   input  logic       slot_free,
   output logic       go,
   output logic       stop_lam,
   output logic       stop_plam
);
   logic [3:0] pace_ok;

   // Controller and Q pacing never hold an issue back; Q pacing acts on the response.
   assign pace_ok   = {plam, lam, 1'b1, 1'b1};
   assign go        = pace_ok[pace_sel] && slot_free;
   assign stop_lam  = (end_sel == END_LAM)  && lam;
   assign stop_plam = (end_sel == END_PLAM) && plam;
endmodule

// File: rtl/btx_outslot.sv
module btx_outslot #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] dout,
   output logic          free
);
   assign free = !valid || ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (push) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/btx_seq.sv
module btx_seq
   import btx_pkg::*;
#(
   parameter int NW      = 5,
   parameter int AW      = 4,
   parameter int FW      = 5,
   parameter int DW      = 24,
   parameter int CW      = 16,
   parameter bit SCAN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [5:0]       req_mode,
   input  logic [NW+AW-1:0] req_start,
   input  logic [NW+AW-1:0] req_term,
   input  logic [CW-1:0]    req_wcnt,
   input  logic [FW-1:0]    req_func,
   output logic             cmd_stb,
   output logic [NW-1:0]    cmd_n,
   output logic [AW-1:0]    cmd_a,
   output logic [FW-1:0]    cmd_f,
   input  logic             dw_q,
   input  logic             dw_lam,
   input  logic             dw_plam,
   input  logic [DW-1:0]    dw_rdata,
   output logic             host_valid,
   input  logic             host_ready,
   output logic [DW-1:0]    host_data,
   output logic             busy,
   output logic             done,
   output logic [CW-1:0]    st_words,
   output logic [NW+AW-1:0] st_last,
   output logic [2:0]       st_cause
);
   localparam int AD = NW + AW;
   localparam logic [CW-1:0] ONE = CW'(1);

   initial begin
      assert (NW >= 1 && AW >= 1 && FW >= 1 && DW >= 1 && CW >= 2)
         else $fatal(1, "btx_seq: parameter out of range");
   end

   seq_st_t         st;
   logic            scan_r;
   logic [1:0]      pace_r;
   logic [2:0]      end_r;
   logic [AD-1:0]   cur;
   logic [AD-1:0]   term_r;
   logic [CW-1:0]   lim_r;
   logic [FW-1:0]   func_r;
   logic [CW-1:0]   words_r;
   logic [AD-1:0]   last_r;
   logic [2:0]      cause_r;
   logic [AD:0]     nxt;
   logic            scan_req;
   logic            go, stop_lam, stop_plam, slot_free;
   logic            issuing, retry, word, fin;
   logic [2:0]      fin_cause;
   logic [CW-1:0]   words_inc;

   generate
      if (SCAN_EN) begin : g_scan
         btx_addr_step #(.NW(NW), .AW(AW)) u_step (
            .cur_n (cur[AD-1:AW]),
            .cur_a (cur[AW-1:0]),
            .q     (dw_q),
            .nxt   (nxt)
         );
         assign scan_req = req_mode[0];
      end else begin : g_fixed
         assign nxt      = {1'b0, cur};
         assign scan_req = 1'b0;
      end
   endgenerate

   btx_gate u_gate (
      .pace_sel  (pace_r),
      .end_sel   (end_r),
      .lam       (dw_lam),
      .plam      (dw_plam),
      .slot_free (slot_free),
      .go        (go),
      .stop_lam  (stop_lam),
      .stop_plam (stop_plam)
   );

   assign issuing   = (st == ST_ISSUE);
   assign retry     = issuing && (pace_r == PACE_Q) && !dw_q;
   assign word      = issuing && !retry && (dw_q || (end_r == END_QLAST));
   assign words_inc = words_r + ONE;

   btx_outslot #(.DW(DW)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (word),
      .din   (dw_rdata),
      .ready (host_ready),
      .valid (host_valid),
      .dout  (host_data),
      .free  (slot_free)
   );

   // End decision for the operation in flight, in priority order.
   always_comb begin
      fin       = 1'b0;
      fin_cause = CAUSE_NONE;
      if (!issuing || retry) begin
         fin = 1'b0;
      end else if (((end_r == END_QNEXT) || (end_r == END_QLAST)) && !dw_q) begin
         fin       = 1'b1;
         fin_cause = CAUSE_Q;
      end else if (word && (words_inc == lim_r)) begin
         fin       = 1'b1;
         fin_cause = CAUSE_COUNT;
      end else if (scan_r && (nxt > {1'b0, term_r})) begin
         fin       = 1'b1;
         fin_cause = CAUSE_TERM;
      end else if (!scan_r && (end_r == END_TERM) && word && (cur == term_r)) begin
         fin       = 1'b1;
         fin_cause = CAUSE_TERM;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         scan_r  <= 1'b0;
         pace_r  <= PACE_CTRL;
         end_r   <= END_COUNT;
         cur     <= '0;
         term_r  <= '0;
         lim_r   <= '0;
         func_r  <= '0;
         words_r <= '0;
         last_r  <= '0;
         cause_r <= CAUSE_NONE;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  scan_r  <= scan_req;
                  pace_r  <= req_mode[2:1];
                  end_r   <= req_mode[5:3];
                  cur     <= req_start;
                  last_r  <= req_start;
                  term_r  <= req_term;
                  lim_r   <= req_wcnt;
                  func_r  <= req_func;
                  words_r <= '0;
                  if (req_wcnt == '0) begin
                     cause_r <= CAUSE_COUNT;
                     st      <= ST_DONE;
                  end else begin
                     cause_r <= CAUSE_NONE;
                     st      <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (stop_lam) begin
                  cause_r <= CAUSE_LAM;
                  st      <= ST_DONE;
               end else if (stop_plam) begin
                  cause_r <= CAUSE_PLAM;
                  st      <= ST_DONE;
               end else if (go) begin
                  st <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               last_r <= cur;
               if (word)
                  words_r <= words_inc;
               if (fin) begin
                  cause_r <= fin_cause;
                  st      <= ST_DONE;
               end else begin
                  if (scan_r && !retry)
                     cur <= nxt[AD-1:0];
                  st <= ST_WAIT;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_DONE);
   assign cmd_stb   = issuing;
   assign cmd_n     = cur[AD-1:AW];
   assign cmd_a     = cur[AW-1:0];
   assign cmd_f     = func_r;
   assign st_words  = words_r;
   assign st_last   = last_r;
   assign st_cause  = cause_r;
endmodule

// File: rtl/btx_seq_chk.sv
module btx_seq_chk
   import btx_pkg::*;
#(
   parameter int NW = 5,
   parameter int AW = 4,
   parameter int DW = 24,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          cmd_stb,
   input logic [NW-1:0] cmd_n,
   input logic [AW-1:0] cmd_a,
   input logic          dw_lam,
   input logic          dw_plam,
   input logic          host_valid,
   input logic          host_ready,
   input logic [DW-1:0] host_data,
   input logic          busy,
   input logic          done,
   input logic [CW-1:0] st_words,
   input logic          scan_r,
   input logic [1:0]    pace_r,
   input logic [CW-1:0] lim_r
);
   a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   a_r2_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !scan_r) |-> $stable({cmd_n, cmd_a}));

   a_r6_lam_pace: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && (pace_r == PACE_LAM)) |-> $past(dw_lam));

   a_r6_plam_pace: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && (pace_r == PACE_PLAM)) |-> $past(dw_plam));

   a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (st_words <= lim_r));

   a_r10_slot_empty: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> !host_valid);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_ready) |=> (host_valid && $stable(host_data)));

   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind btx_seq btx_seq_chk #(.NW(NW), .AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/sim_btx_seq.sv
module sim_btx_seq;
   localparam int NW = 5, AW = 4, FW = 5, DW = 24, CW = 16;
   localparam int NV = 10;

   typedef struct packed {
      logic [5:0]       mode;
      logic [NW+AW-1:0] start;
      logic [NW+AW-1:0] term;
      logic [CW-1:0]    wcnt;
      logic [15:0]      qpat;
      logic [7:0]       strobes;
      logic [CW-1:0]    words;
      logic [2:0]       cause;
      logic [NW+AW-1:0] last;
      logic [DW-1:0]    ldata;
   } vec_t;

   // mode = {end, pace, addr}; address = {station, subaddress}
   localparam vec_t VECS [NV] = '{
      '{{3'd0,2'd0,1'b0}, {5'd3,4'd2},  9'd0,         16'd4,  16'hFFFF, 8'd4, 16'd4, 3'd1, {5'd3,4'd2}, 24'h003203},
      '{{3'd2,2'd0,1'b0}, {5'd3,4'd2},  9'd0,         16'd10, 16'h0007, 8'd4, 16'd3, 3'd3, {5'd3,4'd2}, 24'h003202},
      '{{3'd3,2'd0,1'b0}, {5'd3,4'd2},  9'd0,         16'd10, 16'h0007, 8'd4, 16'd4, 3'd3, {5'd3,4'd2}, 24'h003203},
      '{{3'd0,2'd1,1'b0}, {5'd3,4'd2},  9'd0,         16'd3,  16'h0032, 8'd6, 16'd3, 3'd1, {5'd3,4'd2}, 24'h003205},
      '{{3'd1,2'd0,1'b1}, {5'd2,4'd14}, {5'd3,4'd1},  16'd20, 16'hFFFF, 8'd4, 16'd4, 3'd2, {5'd3,4'd1}, 24'h003103},
      '{{3'd1,2'd0,1'b1}, {5'd1,4'd0},  {5'd3,4'd0},  16'd20, 16'h0005, 8'd5, 16'd2, 3'd2, {5'd3,4'd0}, 24'h002002},
      '{{3'd0,2'd0,1'b1}, {5'd1,4'd5},  {5'd20,4'd0}, 16'd2,  16'hFFFF, 8'd2, 16'd2, 3'd1, {5'd1,4'd6}, 24'h001601},
      '{{3'd1,2'd0,1'b0}, {5'd4,4'd4},  {5'd4,4'd4},  16'd9,  16'hFFFF, 8'd1, 16'd1, 3'd2, {5'd4,4'd4}, 24'h004400},
      '{{3'd0,2'd0,1'b0}, {5'd5,4'd5},  9'd0,         16'd0,  16'hFFFF, 8'd0, 16'd0, 3'd1, {5'd5,4'd5}, 24'h000000},
      '{{3'd4,2'd0,1'b0}, {5'd3,4'd2},  9'd0,         16'd3,  16'hFFFF, 8'd3, 16'd3, 3'd1, {5'd3,4'd2}, 24'h003202}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             req_valid = 1'b0, req_ready;
   logic [5:0]       req_mode = '0;
   logic [NW+AW-1:0] req_start = '0, req_term = '0;
   logic [CW-1:0]    req_wcnt = '0;
   logic [FW-1:0]    req_func = 5'd2;
   logic             cmd_stb;
   logic [NW-1:0]    cmd_n;
   logic [AW-1:0]    cmd_a;
   logic [FW-1:0]    cmd_f;
   logic             dw_q, dw_lam = 1'b0, dw_plam = 1'b0;
   logic [DW-1:0]    dw_rdata;
   logic             host_valid, host_ready = 1'b1;
   logic [DW-1:0]    host_data;
   logic             busy, done;
   logic [CW-1:0]    st_words;
   logic [NW+AW-1:0] st_last;
   logic [2:0]       st_cause;

   btx_seq #(.NW(NW), .AW(AW), .FW(FW), .DW(DW), .CW(CW)) u0 (.*);

   // Module model and monitors
   logic [15:0] qpat = 16'hFFFF;
   logic        clr = 1'b0;
   int          sidx = 0, nwords = 0, cyc = 0, first_c = 0, last_c = 0, uni_err = 0;
   logic [DW-1:0] ldata = '0;
   int          total = 0, bad = 0;

   assign dw_q     = qpat[sidx[3:0]];
   assign dw_rdata = {7'd0, cmd_n, cmd_a, sidx[7:0]};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (clr) begin
         sidx <= 0; nwords <= 0; uni_err <= 0; ldata <= '0;
      end else begin
         if (cmd_stb) begin
            sidx <= sidx + 1;
            if (sidx == 0) first_c <= cyc;
            last_c <= cyc;
            if (!req_mode[0] && (({cmd_n, cmd_a} != req_start) || (cmd_f != req_func)))
               uni_err <= uni_err + 1;
         end
         if (host_valid && host_ready) begin
            nwords <= nwords + 1;
            ldata  <= host_data;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic start_req(input logic [5:0] m, input logic [NW+AW-1:0] s,
                            input logic [NW+AW-1:0] t, input logic [CW-1:0] w);
      @(negedge clk);
      clr = 1'b1;
      req_mode = m; req_start = s; req_term = t; req_wcnt = w;
      @(negedge clk);
      clr = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      for (int k = 0; k < 600; k++) begin
         if (done) return;
         @(negedge clk);
      end
      chk({tag, " done timeout"}, 32'd0, 32'd1);
   endtask

   function automatic string vtag(input int i);
      case (i)
         0: return "R1";
         1, 2: return "R8";
         3: return "R5";
         4, 5, 7: return "R3";
         default: return "R7";
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 req_ready", req_ready, 1);
      chk("R11 busy", busy, 0);
      chk("R11 done", done, 0);
      chk("R11 cmd_stb", cmd_stb, 0);
      chk("R11 host_valid", host_valid, 0);

      for (int i = 0; i < NV; i++) begin
         qpat = VECS[i].qpat;
         start_req(VECS[i].mode, VECS[i].start, VECS[i].term, VECS[i].wcnt);
         wait_done(vtag(i));
         chk({vtag(i), " cause"}, st_cause, VECS[i].cause);
         chk("R11 last", st_last, VECS[i].last);
         repeat (3) @(negedge clk);
         chk({vtag(i), " strobes"}, sidx, VECS[i].strobes);
         chk({vtag(i), " words"}, nwords, VECS[i].words);
         chk("R11 words", st_words, VECS[i].words);
         chk({vtag(i), " last data"}, ldata, VECS[i].ldata);
         if (!VECS[i].mode[0]) chk("R2 fixed address", uni_err, 0);
         if (VECS[i].strobes > 0)
            chk("R4 spacing", last_c - first_c, 2 * (VECS[i].strobes - 1));
      end
      qpat = 16'hFFFF;

      // R6 LAM pacing: nothing issues until the line rises
      start_req({3'd0, 2'd2, 1'b0}, {5'd3, 4'd2}, 9'd0, 16'd2);
      repeat (10) @(negedge clk);
      chk("R6 no strobe while LAM low", sidx, 0);
      chk("R6 still busy", busy, 1);
      dw_lam = 1'b1;
      wait_done("R6");
      dw_lam = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 strobes after LAM", sidx, 2);

      // R10 back-pressure, then R9 LAM end
      host_ready = 1'b0;
      start_req({3'd4, 2'd0, 1'b0}, {5'd3, 4'd2}, 9'd0, 16'd50);
      repeat (10) @(negedge clk);
      chk("R10 one strobe under stall", sidx, 1);
      chk("R10 word held", host_valid, 1);
      chk("R10 held data", host_data, 24'h003200);
      dw_lam = 1'b1;
      wait_done("R9");
      chk("R9 LAM cause", st_cause, 4);
      chk("R9 words at LAM end", st_words, 1);
      dw_lam = 1'b0;
      host_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 no strobe after LAM end", sidx, 1);
      chk("R10 word delivered", nwords, 1);

      // R9 pseudo-LAM end before any operation
      dw_plam = 1'b1;
      start_req({3'd5, 2'd0, 1'b0}, {5'd6, 4'd1}, 9'd0, 16'd5);
      wait_done("R9");
      chk("R9 pseudo-LAM cause", st_cause, 5);
      repeat (3) @(negedge clk);
      chk("R9 no strobe", sidx, 0);
      chk("R11 last equals start", st_last, {5'd6, 4'd1});

      // R6 pseudo-LAM pacing with the line high
      start_req({3'd0, 2'd3, 1'b0}, {5'd3, 4'd2}, 9'd0, 16'd2);
      wait_done("R6");
      dw_plam = 1'b0;
      repeat (5) @(negedge clk);
      chk("R6 pseudo-LAM strobes", sidx, 2);
      chk("R11 status held", st_cause, 1);
      chk("R11 done is a pulse", done, 0);
      chk("R11 idle after done", busy, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule